// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog counter on a small register bus. Software cannot start or halt it with a single write. Each action needs an ordered pair of magic words written to the control offset. Once armed, the counter runs down from a programmable reload value by one per clock. When it runs out, the block stops, raises a sticky interrupt flag and drives a reset pulse for a programmed number of clocks.

The halt pair stops the counter and copies the reload value back into it. A read of the control offset returns the live count, so software can see how much time is left. If a write breaks a pair part way through, the sequence tracker drops back to idle and nothing else changes.

The bus has one write port (enable, offset, data) and a separate combinational read port (offset in, data out). Register offsets are: 0 control/count, 1 reload value, 2 pulse length, 3 flags.

Top module: `seq_watchdog`

## Requirements
- R1: After reset the counter is stopped and holds RESET_COUNT. The reload register reads RESET_COUNT and the pulse length reads RESET_PULSE. The flag register reads zero, and both `wdt_irq` and `wdt_rst` are low.
- R2: A write of 0x0000FF00 to offset 0, followed on the next control write by 0x000000FF, starts the counter. The count is unchanged on the starting edge and drops by one on every clock after it.
- R3: A write of 0x0000EE00 to offset 0, followed on the next control write by 0x000000EE, stops the counter and loads the count from the reload register on that edge.
- R4: After a first magic word, any other value written to offset 0 returns the tracker to idle with no effect. A second word written without its first word also has no effect. Writes to offsets 1 to 3 between the two words do not disturb the tracker.
- R5: The read port returns the live count at offset 0, the reload value at offset 1 and the pulse length (low 16 bits) at offset 2. At offset 3 it returns the expiry flag at bit 3, with every other bit zero.
- R6: On a clock where the counter is running at zero, the counter stops and stays at zero. Bit 3 of the flag register and `wdt_irq` go high on the same edge.
- R7: The expiry edge drives `wdt_rst` high for exactly L clocks, where L is the pulse length, or 1 if the pulse length is zero.
- R8: Writing offset 3 with bit 3 set clears the flag, and writing it with bit 3 clear leaves the flag as it is. If an expiry and a clear fall on the same edge, the flag ends up set.
- R9: If a halt pair completes on the edge where the counter would expire, the halt wins: there is no flag and no pulse, and the count is reloaded.
- R10: A start pair while running does not change the count. A write to the reload register while running does not change the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read offset |
| rd_data | output | 32 | Combinational read data |
| wdt_irq | output | 1 | Expiry flag (sticky, write-one-to-clear) |
| wdt_rst | output | 1 | Reset pulse output |

## Verification
Two pairs of events can land on the same edge. The first is the second halt word against the expiry of a counter that is running at zero. The bench sets up a reload of two and places the halt pair so that its closing word meets the zero count exactly. It then expects a reloaded count with `wdt_irq` and `wdt_rst` both low. The second is a flag clear against a fresh expiry, which must leave the flag set. A cycle-level reference model in the bench follows both cases, and so does a long run of random bus traffic that interleaves magic words, reload and pulse writes, and clears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned OFS_W  = 2;

    localparam logic [BUS_W-1:0] ARM_FIRST  = 32'h0000_FF00;
    localparam logic [BUS_W-1:0] ARM_SECOND = 32'h0000_00FF;
    localparam logic [BUS_W-1:0] HALT_FIRST  = 32'h0000_EE00;
    localparam logic [BUS_W-1:0] HALT_SECOND = 32'h0000_00EE;

    localparam logic [OFS_W-1:0] OFS_CTRL   = 2'd0;
    localparam logic [OFS_W-1:0] OFS_RELOAD = 2'd1;
    localparam logic [OFS_W-1:0] OFS_PULSE  = 2'd2;
    localparam logic [OFS_W-1:0] OFS_FLAGS  = 2'd3;

    localparam int unsigned FLAG_BIT = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ARM  = 2'd1,
        SEQ_HALT = 2'd2
    } seq_e;
endpackage

// File: rtl/wdt_seq_track.sv
module wdt_seq_track
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             arm_evt,
    output logic             halt_evt
);
    typedef struct packed {
        seq_e st;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d    = trk_q;
        arm_evt  = 1'b0;
        halt_evt = 1'b0;
        if (ctrl_wr) begin
            unique case (trk_q.st)
                SEQ_ARM: begin
                    arm_evt  = (wdata == ARM_SECOND);
                    trk_d.st = SEQ_IDLE;
                end
                SEQ_HALT: begin
                    halt_evt = (wdata == HALT_SECOND);
                    trk_d.st = SEQ_IDLE;
                end
                default: begin
                    if (wdata == ARM_FIRST)
                        trk_d.st = SEQ_ARM;
                    else if (wdata == HALT_FIRST)
                        trk_d.st = SEQ_HALT;
                    else
                        trk_d.st = SEQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trk_q <= '{st: SEQ_IDLE};
        else
            trk_q <= trk_d;
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned RESET_COUNT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             halt,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] INIT = CNT_W'(RESET_COUNT);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cd_t;

    cd_t cd_d, cd_q;

    always_comb begin
        cd_d   = cd_q;
        expire = cd_q.run && (cd_q.cnt == '0) && !halt;
        if (halt) begin
            cd_d.run = 1'b0;
            cd_d.cnt = reload_val;
        end else if (expire) begin
            cd_d.run = 1'b0;
        end else begin
            if (arm)
                cd_d.run = 1'b1;
            if (cd_q.run && (cd_q.cnt != '0))
                cd_d.cnt = cd_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cd_q <= '{run: 1'b0, cnt: INIT};
        else
            cd_q <= cd_d;
    end

    assign count   = cd_q.cnt;
    assign running = cd_q.run;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [LEN_W-1:0] left;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (fire)
            pg_d.left = (len == '0) ? ONE : len;
        else if (pg_q.left != '0)
            pg_d.left = pg_q.left - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pg_q <= '{left: '0};
        else
            pg_q <= pg_d;
    end

    assign active = (pg_q.left != '0);
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned LEN_W       = 16,
    parameter int unsigned RESET_COUNT = 100,
    parameter int unsigned RESET_PULSE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_addr,
    output logic [31:0]      rd_data,
    output logic             wdt_irq,
    output logic             wdt_rst
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [LEN_W-1:0] plen;
        logic             flag;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             ctrl_wr;
    logic             arm_evt;
    logic             halt_evt;
    logic             expire;
    logic             run_w;
    logic [CNT_W-1:0] count_w;
    logic             flag_clr;

    assign ctrl_wr  = wr_en && (wr_addr == OFS_CTRL);
    assign flag_clr = wr_en && (wr_addr == OFS_FLAGS) && wr_data[FLAG_BIT];

    wdt_seq_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wdata    (wr_data),
        .arm_evt  (arm_evt),
        .halt_evt (halt_evt)
    );

    wdt_countdown #(
        .CNT_W       (CNT_W),
        .RESET_COUNT (RESET_COUNT)
    ) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm_evt),
        .halt       (halt_evt),
        .reload_val (regs_q.reload),
        .count      (count_w),
        .running    (run_w),
        .expire     (expire)
    );

    wdt_pulse #(
        .LEN_W (LEN_W)
    ) u_pg (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (expire),
        .len    (regs_q.plen),
        .active (wdt_rst)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr == OFS_RELOAD))
            regs_d.reload = wr_data[CNT_W-1:0];
        if (wr_en && (wr_addr == OFS_PULSE))
            regs_d.plen = wr_data[LEN_W-1:0];
        if (flag_clr)
            regs_d.flag = 1'b0;
        if (expire)
            regs_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '{reload: CNT_W'(RESET_COUNT), plen: LEN_W'(RESET_PULSE), flag: 1'b0};
        else
            regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_CTRL:   rd_data = BUS_W'(count_w);
            OFS_RELOAD: rd_data = BUS_W'(regs_q.reload);
            OFS_PULSE:  rd_data = BUS_W'(regs_q.plen);
            default:    rd_data[FLAG_BIT] = regs_q.flag;
        endcase
    end

    assign wdt_irq = regs_q.flag;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             halt,
    input logic             arm,
    input logic [CNT_W-1:0] reload,
    input logic             flag,
    input logic             pulse,
    input logic             clr
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && (count != '0) && !halt |=> count == $past(count) - ONE);

    // R3
    halt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !running && (count == $past(reload)));

    // R4
    stay_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !arm |=> !running);

    // R6
    expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && (count == '0) && !halt |=> flag && !running && (count == '0));

    // R7
    pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
endmodule

bind seq_watchdog wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (run_w),
    .count   (count_w),
    .halt    (halt_evt),
    .arm     (arm_evt),
    .reload  (regs_q.reload),
    .flag    (wdt_irq),
    .pulse   (wdt_rst),
    .clr     (flag_clr)
);

// File: tb/seq_watchdog_tb.sv
module seq_watchdog_tb;
    localparam logic [31:0] A1 = 32'h0000_FF00, A2 = 32'h0000_00FF;
    localparam logic [31:0] H1 = 32'h0000_EE00, H2 = 32'h0000_00EE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wdt_irq;
    logic        wdt_rst;

    int checks = 0;
    int fails  = 0;

    bit [31:0] m_cnt, m_reload;
    bit [15:0] m_plen, m_pcnt;
    bit        m_run, m_stat;
    int        m_seq;

    always #5 clk = ~clk;

    seq_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_rd(input bit [1:0] ra);
        case (ra)
            2'd0:    return m_cnt;
            2'd1:    return m_reload;
            2'd2:    return {16'h0, m_plen};
            default: return {28'h0, m_stat, 3'b000};
        endcase
    endfunction

    task automatic model_step(input bit wr, input bit [1:0] a, input bit [31:0] d);
        bit start, stop, expire;
        start  = wr && a == 0 && m_seq == 1 && d == A2;
        stop   = wr && a == 0 && m_seq == 2 && d == H2;
        expire = m_run && m_cnt == 0 && !stop;
        if (wr && a == 0)
            m_seq = (m_seq != 0) ? 0 : (d == A1) ? 1 : (d == H1) ? 2 : 0;
        if (stop) begin
            m_run = 0; m_cnt = m_reload;
        end else if (expire) begin
            m_run = 0;
        end else begin
            if (m_run && m_cnt != 0) m_cnt = m_cnt - 1;
            if (start) m_run = 1;
        end
        if (wr && a == 3 && d[3]) m_stat = 0;
        if (expire) m_stat = 1;
        if (expire) m_pcnt = (m_plen == 0) ? 16'd1 : m_plen;
        else if (m_pcnt != 0) m_pcnt = m_pcnt - 1;
        if (wr && a == 1) m_reload = d;
        if (wr && a == 2) m_plen = d[15:0];
    endtask

    task automatic cyc(input bit wr, input bit [1:0] a, input bit [31:0] d,
                       input bit [1:0] ra, input string tag);
        @(negedge clk);
        wr_en = wr; wr_addr = a; wr_data = d; rd_addr = ra;
        model_step(wr, a, d);
        @(posedge clk);
        #2;
        check({tag, " rd"}, rd_data, exp_rd(ra));
        check({tag, " irq"}, {31'h0, wdt_irq}, {31'h0, m_stat});
        check({tag, " rst"}, {31'h0, wdt_rst}, {31'h0, (m_pcnt != 0)});
    endtask

    task automatic idle(input bit [1:0] ra, input string tag);
        cyc(0, 0, 0, ra, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        m_cnt = 100; m_reload = 100; m_plen = 8; m_pcnt = 0;
        m_run = 0; m_stat = 0; m_seq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 and R5: reset values through the read port
        for (int r = 0; r < 4; r++) idle(2'(r), "R1");
        idle(0, "R1"); check("R1 count", rd_data, 32'd100);
        idle(2, "R5"); check("R5 pulse", rd_data, 32'd8);

        // R3: reload 5, pulse 3, halt pair
        cyc(1, 1, 5, 1, "R5");
        cyc(1, 2, 3, 2, "R5");
        cyc(1, 0, H1, 0, "R3");
        cyc(1, 0, H2, 0, "R3");
        check("R3 reloaded", rd_data, 32'd5);

        // R2: start then countdown
        cyc(1, 0, A1, 0, "R2");
        cyc(1, 0, A2, 0, "R2");
        check("R2 start edge", rd_data, 32'd5);
        for (int k = 4; k >= 0; k--) begin
            idle(0, "R2");
            check("R2 dec", rd_data, 32'(k));
        end
        // R6 and R7: expiry then 3-cycle pulse
        idle(3, "R6");
        check("R6 flag", rd_data, 32'h8);
        check("R7 rst on", {31'h0, wdt_rst}, 32'd1);
        idle(0, "R6");
        check("R6 stays zero", rd_data, 32'd0);
        idle(0, "R7");
        check("R7 rst still", {31'h0, wdt_rst}, 32'd1);
        idle(0, "R7");
        check("R7 rst off", {31'h0, wdt_rst}, 32'd0);

        // R8: write-one-to-clear
        cyc(1, 3, 32'h7, 3, "R8");
        check("R8 no clear", {31'h0, wdt_irq}, 32'd1);
        cyc(1, 3, 32'h8, 3, "R8");
        check("R8 cleared", {31'h0, wdt_irq}, 32'd0);

        // R4: broken sequences
        cyc(1, 0, H1, 0, "R4"); cyc(1, 0, H2, 0, "R4");
        cyc(1, 0, A1, 0, "R4"); cyc(1, 0, 32'h1234, 0, "R4"); cyc(1, 0, A2, 0, "R4");
        cyc(1, 0, A1, 0, "R4"); cyc(1, 0, A1, 0, "R4"); cyc(1, 0, A2, 0, "R4");
        cyc(1, 0, A2, 0, "R4");
        idle(0, "R4"); idle(0, "R4");
        check("R4 still stopped", rd_data, 32'd5);
        cyc(1, 0, A1, 0, "R4"); cyc(1, 1, 6, 0, "R4"); cyc(1, 0, A2, 0, "R4");
        idle(0, "R4");
        check("R4 other offset kept pair", rd_data, 32'd4);

        // R10: rearm and reload writes while running
        cyc(1, 0, A1, 0, "R10"); cyc(1, 0, A2, 0, "R10");
        check("R10 rearm ignored", rd_data, 32'd2);
        cyc(1, 1, 20, 0, "R10");
        check("R10 reload write", rd_data, 32'd1);
        cyc(1, 0, H1, 0, "R10"); cyc(1, 0, H2, 0, "R10");
        check("R10 halt loads new", rd_data, 32'd20);

        // R9: halt completes on the expiry edge
        cyc(1, 3, 32'h8, 3, "R9");
        cyc(1, 1, 2, 0, "R9");
        cyc(1, 0, H1, 0, "R9"); cyc(1, 0, H2, 0, "R9");
        cyc(1, 0, A1, 0, "R9"); cyc(1, 0, A2, 0, "R9");
        idle(0, "R9");
        cyc(1, 0, H1, 0, "R9");
        cyc(1, 0, H2, 0, "R9");
        check("R9 reloaded", rd_data, 32'd2);
        check("R9 no irq", {31'h0, wdt_irq}, 32'd0);
        check("R9 no rst", {31'h0, wdt_rst}, 32'd0);

        // R8: clear and expiry on the same edge, set wins; R7 zero length gives 1
        cyc(1, 2, 0, 0, "R7");
        cyc(1, 1, 1, 0, "R8");
        cyc(1, 0, H1, 0, "R8"); cyc(1, 0, H2, 0, "R8");
        cyc(1, 0, A1, 0, "R8"); cyc(1, 0, A2, 0, "R8");
        idle(0, "R8");
        cyc(1, 3, 32'h8, 3, "R8");
        check("R8 set wins", {31'h0, wdt_irq}, 32'd1);
        check("R7 min pulse", {31'h0, wdt_rst}, 32'd1);
        idle(0, "R7");
        check("R7 min pulse end", {31'h0, wdt_rst}, 32'd0);

        // Random traffic against the model (R2 R3 R4 R6 R7 R8)
        for (int i = 0; i < 3000; i++) begin
            int unsigned sel;
            bit [1:0] ra;
            sel = $urandom % 16;
            ra  = 2'($urandom % 4);
            case (sel)
                0, 1, 2:  cyc(1, 0, A1, ra, "R2 rnd");
                3, 4:     cyc(1, 0, A2, ra, "R2 rnd");
                5, 6:     cyc(1, 0, H1, ra, "R3 rnd");
                7, 8:     cyc(1, 0, H2, ra, "R3 rnd");
                9:        cyc(1, 0, $urandom, ra, "R4 rnd");
                10:       cyc(1, 1, $urandom % 24, ra, "R5 rnd");
                11:       cyc(1, 2, $urandom % 6, ra, "R7 rnd");
                12:       cyc(1, 3, $urandom % 16, ra, "R8 rnd");
                13: begin
                    cyc(1, 0, A1, ra, "R6 rnd");
                    cyc(1, 0, A2, ra, "R6 rnd");
                end
                default:  idle(ra, "R6 rnd");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule